// File: doc/BRIEF.md
# Cooperative Multi-Lane Address Generator

This block produces one 16-bit load/store address per cycle for each of four SIMD lanes. The addresses go to a banked local data memory. Each lane keeps its own base register, pointer register, circular length register and bit-reverse width register. One shared hop register sets the lane stride. Software loads all of these through a narrow configuration write port.

Each request carries a per-lane mode and a per-lane signed immediate, plus a cooperative flag. When the flag is clear, every lane forms its address from its own registers using one of four modes:
- linear with post-increment
- base-plus-offset
- bit-reversed
- circular

When the flag is set, only lane 0 computes an address. Every other lane takes lane 0's address plus its own index times the hop. Results are registered and appear one cycle after the request.

Top module: `mlane_agu`

## Requirements
- R1: After reset `addrValid` is 0, `addrOut` is 0, and every base, pointer, length, width and hop register is 0.
- R2: A request with `reqValid` high at a rising edge makes `addrValid` high after that edge, with the lane addresses on `addrOut`. Lane i occupies bits [16i+15:16i]. A cycle with `reqValid` low leaves `addrValid` low after the edge and `addrOut` unchanged.
- R3: When `cfgWe` is high, `cfgData` is written to the register that `cfgField` selects in lane `cfgLane`. The codes are: 0 base, 1 pointer, 2 circular length, 3 bit-reverse width (low 4 bits), and 4 hop (shared by all lanes, so the lane is ignored). Codes 5 to 7 change nothing.
- R4: Mode code 0 (linear), taken from `reqMode` bits [2i+1:2i]: the address is the pointer, and the pointer then becomes pointer + immediate, modulo 2^16.
- R5: Mode code 1 (offset): the address is base + pointer + immediate, modulo 2^16, and the pointer is unchanged.
- R6: Mode code 2 (bit-reversed): the address is base + the low k bits of the pointer in reversed order. Pointer bits at k and above are dropped. k is the width register clamped to the range 1..10. The pointer then advances by the immediate.
- R7: Mode code 3 (circular): the address is base + pointer. The pointer then becomes pointer + immediate, wrapped into [0, length). This holds for length ≥ 1, pointer < length and |immediate| ≤ length, for both positive and negative immediates.
- R8: With `reqCoop` high, lane 0 behaves as in R4 to R7. Lane i (i = 1..3) outputs lane 0's address + hop·i, modulo 2^16. The modes and immediates of lanes 1..3 are ignored, and their pointers do not change.
- R9: With `reqCoop` low, each lane uses only its own mode, immediate and registers, so mixed modes across lanes are independent.
- R10: A request and a configuration write in the same cycle: the request uses the register values from before the write. If the write targets the pointer of a lane that also steps, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLane | input | 2 | Lane selected by the write |
| cfgField | input | 3 | Register selected by the write (codes in R3) |
| cfgData | input | 16 | Write data |
| reqValid | input | 1 | Address request |
| reqCoop | input | 1 | Cooperative mode for this request |
| reqMode | input | 8 | Two-bit mode per lane |
| reqImm | input | 64 | Signed 16-bit immediate per lane |
| addrValid | output | 1 | Registered addresses valid |
| addrOut | output | 64 | Registered 16-bit address per lane |

## Verification
A configuration write and an address request can land on the same clock edge. In that case the pointer post-update and the software pointer load compete for the same register, and a base or length write races the address that reads it. The bench provokes this with directed cycles that write a lane's pointer while that lane steps in linear mode, and that rewrite a base during an offset-mode request. It also mixes random writes into random request cycles. Each case is judged two ways: the address of that cycle must reflect the old register values, and a later offset-mode request with zero immediate exposes the pointer that remained.

// File: rtl/mlane_agu_pkg.sv
package mlane_agu_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_OFS  = 2'd1,
    MODE_REV  = 2'd2,
    MODE_CIRC = 2'd3
  } laneMode_e;

  typedef enum logic [2:0] {
    FLD_BASE  = 3'd0,
    FLD_PTR   = 3'd1,
    FLD_LEN   = 3'd2,
    FLD_WIDTH = 3'd3,
    FLD_HOP   = 3'd4
  } cfgField_e;

  typedef struct packed {
    logic [LANES-1:0] wrBase;
    logic [LANES-1:0] wrPtr;
    logic [LANES-1:0] wrLen;
    logic [LANES-1:0] wrWidth;
    logic             wrHop;
    logic             issue;
    logic             coop;
    logic [LANES-1:0] ptrStep;
  } ctrlStrobe_t;
endpackage

// File: rtl/mlane_agu_ctrl.sv
module mlane_agu_ctrl
  import mlane_agu_pkg::*;
#(
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                 cfgWe,
  input  logic [LANE_W-1:0]    cfgLane,
  input  logic [2:0]           cfgField,
  input  logic                 reqValid,
  input  logic                 reqCoop,
  input  logic [2*LANES-1:0]   reqMode,
  output ctrlStrobe_t          strobe
);
  logic [LANES-1:0] laneHit;

  always_comb begin
    laneHit = '0;
    if (cfgWe) laneHit = {{(LANES-1){1'b0}}, 1'b1} << cfgLane;
  end

  always_comb begin
    strobe = '0;
    case (cfgField)
      FLD_BASE:  strobe.wrBase  = laneHit;
      FLD_PTR:   strobe.wrPtr   = laneHit;
      FLD_LEN:   strobe.wrLen   = laneHit;
      FLD_WIDTH: strobe.wrWidth = laneHit;
      FLD_HOP:   strobe.wrHop   = cfgWe;
      default:   ;
    endcase
    strobe.issue = reqValid;
    strobe.coop  = reqCoop;
    for (int i = 0; i < LANES; i++) begin
      strobe.ptrStep[i] = reqValid && (!reqCoop || i == 0) &&
                          (reqMode[2*i +: 2] != MODE_OFS);
    end
  end
endmodule

// File: rtl/mlane_agu_dp.sv
module mlane_agu_dp
  import mlane_agu_pkg::*;
#(
  parameter int AW      = 16,
  parameter int REV_MAX = 10,
  parameter int WID_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [AW-1:0]        cfgData,
  input  logic [2*LANES-1:0]   reqMode,
  input  logic [LANES*AW-1:0]  reqImm,
  output logic                 addrValid,
  output logic [LANES*AW-1:0]  addrOut
);
  localparam int SW = AW + 2;
  localparam logic [WID_W-1:0] REV_MAX_W = WID_W'(REV_MAX);
  localparam logic [WID_W-1:0] REV_MIN_W = WID_W'(1);

  logic [AW-1:0]    baseR [LANES];
  logic [AW-1:0]    ptrR  [LANES];
  logic [AW-1:0]    lenR  [LANES];
  logic [WID_W-1:0] widR  [LANES];
  logic [AW-1:0]    hopR;

  logic [LANES*AW-1:0] ownAddrBus;
  logic [LANES*AW-1:0] nextPtrBus;
  logic [LANES*AW-1:0] outAddrBus;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam logic [AW-1:0] LANE_IDX = AW'(g);
    laneMode_e         laneMode;
    logic [AW-1:0]     imm;
    logic [WID_W-1:0]  kEff;
    logic [REV_MAX-1:0] mirror;
    logic [REV_MAX-1:0] revBits;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lenS;
    logic signed [SW-1:0] wrapped;
    logic [AW-1:0]     ownAddr;
    logic [AW-1:0]     nextPtr;

    assign laneMode = laneMode_e'(reqMode[2*g +: 2]);
    assign imm      = reqImm[g*AW +: AW];

    always_comb begin
      if (widR[g] < REV_MIN_W)      kEff = REV_MIN_W;
      else if (widR[g] > REV_MAX_W) kEff = REV_MAX_W;
      else                          kEff = widR[g];
      for (int j = 0; j < REV_MAX; j++) mirror[REV_MAX-1-j] = ptrR[g][j];
      revBits = mirror >> (REV_MAX_W - kEff);
    end

    always_comb begin
      sum  = $signed({2'b00, ptrR[g]}) + $signed({{2{imm[AW-1]}}, imm});
      lenS = $signed({2'b00, lenR[g]});
      if (sum >= lenS)     wrapped = sum - lenS;
      else if (sum < 0)    wrapped = sum + lenS;
      else                 wrapped = sum;
    end

    always_comb begin
      case (laneMode)
        MODE_LIN: begin
          ownAddr = ptrR[g];
          nextPtr = ptrR[g] + imm;
        end
        MODE_OFS: begin
          ownAddr = baseR[g] + ptrR[g] + imm;
          nextPtr = ptrR[g];
        end
        MODE_REV: begin
          ownAddr = baseR[g] + AW'(revBits);
          nextPtr = ptrR[g] + imm;
        end
        default: begin
          ownAddr = baseR[g] + ptrR[g];
          nextPtr = wrapped[AW-1:0];
        end
      endcase
    end

    assign ownAddrBus[g*AW +: AW] = ownAddr;
    assign nextPtrBus[g*AW +: AW] = nextPtr;

    if (g == 0) begin : gLead
      assign outAddrBus[g*AW +: AW] = ownAddr;
    end else begin : gFollow
      assign outAddrBus[g*AW +: AW] = strobe.coop ?
        (ownAddrBus[AW-1:0] + hopR * LANE_IDX) : ownAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hopR <= '0;
      for (int i = 0; i < LANES; i++) begin
        baseR[i] <= '0;
        ptrR[i]  <= '0;
        lenR[i]  <= '0;
        widR[i]  <= '0;
      end
    end else begin
      if (strobe.wrHop) hopR <= cfgData;
      for (int i = 0; i < LANES; i++) begin
        if (strobe.wrBase[i])  baseR[i] <= cfgData;
        if (strobe.wrLen[i])   lenR[i]  <= cfgData;
        if (strobe.wrWidth[i]) widR[i]  <= cfgData[WID_W-1:0];
        if (strobe.wrPtr[i])        ptrR[i] <= cfgData;
        else if (strobe.ptrStep[i]) ptrR[i] <= nextPtrBus[i*AW +: AW];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
    end else begin
      addrValid <= strobe.issue;
      if (strobe.issue) addrOut <= outAddrBus;
    end
  end
endmodule

// File: rtl/mlane_agu.sv
module mlane_agu
  import mlane_agu_pkg::*;
#(
  parameter int AW      = 16,
  parameter int REV_MAX = 10,
  parameter int WID_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgLane,
  input  logic [2:0]          cfgField,
  input  logic [AW-1:0]       cfgData,
  input  logic                reqValid,
  input  logic                reqCoop,
  input  logic [2*LANES-1:0]  reqMode,
  input  logic [LANES*AW-1:0] reqImm,
  output logic                addrValid,
  output logic [LANES*AW-1:0] addrOut
);
  ctrlStrobe_t      strobe;
  logic [LANES-1:0] stepLanes;

  assign stepLanes = strobe.ptrStep;

  mlane_agu_ctrl #(.LANE_W(2)) u_ctrl (
    .cfgWe    (cfgWe),
    .cfgLane  (cfgLane),
    .cfgField (cfgField),
    .reqValid (reqValid),
    .reqCoop  (reqCoop),
    .reqMode  (reqMode),
    .strobe   (strobe)
  );

  mlane_agu_dp #(.AW(AW), .REV_MAX(REV_MAX), .WID_W(WID_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgData   (cfgData),
    .reqMode   (reqMode),
    .reqImm    (reqImm),
    .addrValid (addrValid),
    .addrOut   (addrOut)
  );
endmodule

// File: rtl/mlane_agu_checker.sv
module mlane_agu_checker
  import mlane_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqCoop,
  input logic [2*LANES-1:0]  reqMode,
  input logic                addrValid,
  input logic [LANES*AW-1:0] addrOut,
  input logic [LANES-1:0]    stepLanes
);
  logic [AW-1:0] gap1, gap2, gap3;
  assign gap1 = addrOut[2*AW-1:AW]   - addrOut[AW-1:0];
  assign gap2 = addrOut[3*AW-1:2*AW] - addrOut[2*AW-1:AW];
  assign gap3 = addrOut[4*AW-1:3*AW] - addrOut[3*AW-1:2*AW];

  AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && $stable(addrOut))); // R2
  AST_COOP_EVEN_GAPS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCoop) |=> (gap1 == gap2 && gap2 == gap3)); // R8
  AST_COOP_FOLLOWERS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCoop) |-> (stepLanes[LANES-1:1] == '0)); // R8
  AST_STEP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|stepLanes) |-> reqValid); // R4
  AST_OFS_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCoop && reqMode[1:0] == 2'd1) |-> !stepLanes[0]); // R5
endmodule

bind mlane_agu mlane_agu_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqCoop   (reqCoop),
  .reqMode   (reqMode),
  .addrValid (addrValid),
  .addrOut   (addrOut),
  .stepLanes (stepLanes)
);

// File: tb/mlane_agu_bench.sv
`timescale 1ns/1ps
module mlane_agu_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgLane = '0;
  logic [2:0]  cfgField = '0;
  logic [15:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqCoop = 1'b0;
  logic [7:0]  reqMode = '0;
  logic [63:0] reqImm = '0;
  logic        addrValid;
  logic [63:0] addrOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] mBase [4];
  logic [15:0] mPtr  [4];
  logic [15:0] mLen  [4];
  logic [3:0]  mWid  [4];
  logic [15:0] mHop;
  logic [63:0] lastOut;

  always #2.5 clk = ~clk;

  mlane_agu u_mlane_agu (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgLane(cfgLane),
    .cfgField(cfgField), .cfgData(cfgData), .reqValid(reqValid),
    .reqCoop(reqCoop), .reqMode(reqMode), .reqImm(reqImm),
    .addrValid(addrValid), .addrOut(addrOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] revK(input logic [15:0] v, input int k);
    logic [15:0] r = '0;
    for (int j = 0; j < k; j++) r[k-1-j] = v[j];
    return r;
  endfunction

  function automatic int clampK(input logic [3:0] w);
    if (w == 0) return 1;
    if (w > 10) return 10;
    return int'(w);
  endfunction

  // One cycle: optional request and optional configuration write, then check.
  task automatic doOp(input bit doReq, input bit coop, input logic [7:0] mode,
                      input logic [63:0] imm, input bit doCfg, input int lane,
                      input int fld, input logic [15:0] data, input string tag);
    logic [15:0] ea [4];
    logic [15:0] np [4];
    bit step [4];
    @(negedge clk);
    reqValid = doReq; reqCoop = coop; reqMode = mode; reqImm = imm;
    cfgWe = doCfg; cfgLane = lane[1:0]; cfgField = fld[2:0]; cfgData = data;
    for (int l = 0; l < 4; l++) begin
      logic [15:0] im;
      int s;
      im = imm[16*l +: 16];
      np[l] = mPtr[l];
      step[l] = 1;
      case (mode[2*l +: 2])
        2'd0: begin ea[l] = mPtr[l]; np[l] = mPtr[l] + im; end
        2'd1: begin ea[l] = mBase[l] + mPtr[l] + im; step[l] = 0; end
        2'd2: begin ea[l] = mBase[l] + revK(mPtr[l], clampK(mWid[l])); np[l] = mPtr[l] + im; end
        default: begin
          ea[l] = mBase[l] + mPtr[l];
          s = int'(mPtr[l]) + int'($signed(im));
          if (s >= int'(mLen[l])) s -= int'(mLen[l]);
          else if (s < 0) s += int'(mLen[l]);
          np[l] = 16'(s);
        end
      endcase
    end
    if (coop) for (int l = 1; l < 4; l++) begin
      ea[l] = ea[0] + 16'(mHop * 16'(l));
      step[l] = 0;
    end
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    if (doReq) begin
      chk(addrValid === 1'b1, {tag, " R2 valid"}, 64'(addrValid), 64'd1);
      for (int l = 0; l < 4; l++)
        chk(addrOut[16*l +: 16] === ea[l], tag, 64'(addrOut[16*l +: 16]), 64'(ea[l]));
      for (int l = 0; l < 4; l++) if (step[l]) mPtr[l] = np[l];
    end else begin
      chk(addrValid === 1'b0, {tag, " R2 idle valid"}, 64'(addrValid), 64'd0);
      chk(addrOut === lastOut, {tag, " R2 idle hold"}, addrOut, lastOut);
    end
    if (doCfg) begin
      case (fld)
        0: mBase[lane] = data;
        1: mPtr[lane]  = data;
        2: mLen[lane]  = data;
        3: mWid[lane]  = data[3:0];
        4: mHop        = data;
        default: ;
      endcase
    end
    lastOut = addrOut;
  endtask

  task automatic cfg(input int lane, input int fld, input logic [15:0] data);
    doOp(0, 0, 8'h00, 64'h0, 1, lane, fld, data, "R3 cfg");
  endtask

  task automatic req(input bit coop, input logic [7:0] mode, input logic [63:0] imm, input string tag);
    doOp(1, coop, mode, imm, 0, 0, 0, 16'h0, tag);
  endtask

  function automatic logic [63:0] packImm(input logic [15:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int l = 0; l < 4; l++) begin
      mBase[l] = 0; mPtr[l] = 0; mLen[l] = 0; mWid[l] = 0;
    end
    mHop = 0; lastOut = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(addrValid === 1'b0, "R1 reset valid", 64'(addrValid), 64'd0);
    chk(addrOut === 64'd0, "R1 reset addr", addrOut, 64'd0);
    req(0, 8'h55, 64'h0, "R1 regs zero");
    req(1, 8'h01, 64'h0, "R1 hop zero");

    for (int l = 0; l < 4; l++) begin
      cfg(l, 0, 16'(16'h1000 * (l + 1)));
      cfg(l, 1, 16'(3 * l));
    end
    cfg(0, 4, 16'h0040);
    req(0, 8'h55, 64'h0, "R3 write readback");

    req(0, 8'h00, packImm(16'd4, 16'hFFFF, 16'd0, 16'd7), "R4 linear");
    req(0, 8'h00, packImm(16'd4, 16'hFFFF, 16'd0, 16'd7), "R4 linear post-inc");
    req(0, 8'h55, packImm(16'd2, 16'd2, 16'd2, 16'd2), "R5 offset");
    req(0, 8'h55, packImm(16'd2, 16'd2, 16'd2, 16'd2), "R5 offset ptr held");

    cfg(0, 1, 16'h0001); cfg(0, 3, 16'd3);
    cfg(1, 1, 16'h00F3); cfg(1, 3, 16'd0);
    cfg(2, 1, 16'hFC01); cfg(2, 3, 16'd15);
    cfg(3, 1, 16'h0206); cfg(3, 3, 16'd10);
    req(0, 8'hAA, packImm(16'd1, 16'd1, 16'd1, 16'd1), "R6 bitrev");
    req(0, 8'hAA, packImm(16'd1, 16'd1, 16'd1, 16'd1), "R6 bitrev step");

    cfg(0, 2, 16'd5); cfg(0, 1, 16'd3);
    cfg(1, 2, 16'd5); cfg(1, 1, 16'd0);
    cfg(2, 2, 16'd1); cfg(2, 1, 16'd0);
    cfg(3, 2, 16'd8); cfg(3, 1, 16'd7);
    req(0, 8'hFF, packImm(16'd2, 16'hFFFD, 16'd1, 16'd8), "R7 circular wrap");
    req(0, 8'hFF, packImm(16'hFFFB, 16'd5, 16'hFFFF, 16'hFFF8), "R7 circular negative");
    req(0, 8'h55, 64'h0, "R7 circular ptr readback");

    req(1, 8'hE4, packImm(16'd3, 16'd9, 16'd9, 16'd9), "R8 coop");
    cfg(0, 4, 16'h7000);
    req(1, 8'h1D, packImm(16'd0, 16'd5, 16'd5, 16'd5), "R8 coop hop wrap");
    req(0, 8'h55, 64'h0, "R8 followers ptr unchanged");
    req(0, 8'h1B, packImm(16'd1, 16'd2, 16'd3, 16'd1), "R9 independent mixed");

    doOp(0, 0, 8'h00, 64'h0, 1, 1, 6, 16'hBEEF, "R3 code6 ignored");
    doOp(0, 0, 8'h00, 64'h0, 1, 2, 7, 16'hBEEF, "R3 code7 ignored");
    req(0, 8'h55, 64'h0, "R3 ignored readback");
    req(1, 8'h01, 64'h0, "R3 hop readback");

    doOp(1, 0, 8'h00, packImm(16'd9, 16'd0, 16'd0, 16'd0), 1, 0, 1, 16'h0123, "R10 ptr write wins");
    req(0, 8'h55, 64'h0, "R10 ptr readback");
    doOp(1, 0, 8'h55, 64'h0, 1, 2, 0, 16'h4444, "R10 old base used");
    req(0, 8'h55, 64'h0, "R10 new base");
    doOp(0, 0, 8'h00, 64'h0, 0, 0, 0, 16'h0, "R2 idle");

    for (int it = 0; it < 400; it++) begin
      bit coop, doCfg, doReq;
      logic [7:0] mode;
      logic [63:0] imm;
      coop = ($urandom_range(0, 3) == 0);
      doReq = ($urandom_range(0, 4) != 0);
      doCfg = ($urandom_range(0, 2) == 0);
      mode = 8'($urandom);
      imm = {$urandom, $urandom};
      for (int l = 0; l < 4; l++) begin
        if (mode[2*l +: 2] == 2'd3) begin
          if (mLen[l] == 0 || mPtr[l] >= mLen[l]) mode[2*l +: 2] = 2'd1;
          else imm[16*l +: 16] = 16'($urandom_range(0, 2 * int'(mLen[l])) - int'(mLen[l]));
        end
      end
      if (doCfg) begin
        int fld, lane;
        logic [15:0] d;
        fld = $urandom_range(0, 7);
        lane = $urandom_range(0, 3);
        d = 16'($urandom);
        if (fld == 2) d = 16'($urandom_range(1, 64));
        if (fld == 1) d = 16'($urandom_range(0, 40));
        doOp(doReq, coop, mode, imm, 1, lane, fld, d, "R9 R10 random");
      end else begin
        doOp(doReq, coop, mode, imm, 0, 0, 0, 16'h0, coop ? "R8 random" : "R9 random");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule